// File: doc/BRIEF.md
# Host Controller Capability Register Decoder

This block is the memory-mapped front end for the capability window of a USB 2.0 host controller. A simple bus target presents a word address, a read/write flag, a lock flag, write data and byte enables; one cycle later the block answers with a claim flag, an abort flag and read data. Whether it answers at all depends on three configuration-space inputs: a memory-space enable, a D3 power-state flag and a write-unlock control.

The window holds four fixed or near-fixed registers: a capability-length byte, an interface version, a structural-parameters word and a capability-parameters word. Only the structural-parameters word can be changed, and only while the unlock control is high. Its flops sit in the suspend (always-on) reset domain. The controller's core reset clears the response path but leaves this word alone. Unused words in the window read as zero.

Top module: `hccap_decoder`

## Requirements
- R1: While `cfg_mem_en` is low, a request is never claimed: `bus_claim`, `bus_abort` and `bus_rdata` stay zero and no register changes, whatever the lock and power inputs.
- R2: A request whose address lies outside the 32-byte window starting at `BASE` is not claimed.
- R3: A locked request (`bus_lock` high) to the window is claimed and aborted: `bus_claim`=1, `bus_abort`=1, `bus_rdata`=0, and a locked write changes nothing.
- R4: While `cfg_pwr_d3` is high, a request to the window is claimed and aborted and has no effect, the same as in R3.
- R5: A read of word offset 00h returns 32'h0100_0020: byte 0 holds the capability length 20h, byte 1 is zero, and bytes 3:2 hold the version 0100h.
- R6: A read of offset 08h returns 32'h0000_6871, and writes to offsets 00h and 08h are dropped even with unlock high.
- R7: After suspend reset, offset 04h reads 32'h0010_4208.
- R8: With `cfg_wr_unlock` high, a write to offset 04h updates exactly the bytes whose `bus_be` bit is set (bit n selects data bits 8n+7:8n).
- R9: With `cfg_wr_unlock` low, a write to offset 04h is dropped.
- R10: Asserting the core reset clears the response outputs and leaves the value at offset 04h unchanged.
- R11: Reads of offsets 0Ch through 1Ch return zero.
- R12: The response appears in the cycle after the request. In a cycle after no request, all three response outputs are zero. A write returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_sw_n | input | 1 | Suspend-well reset, active low; clears the structural-parameters word |
| rst_core_n | input | 1 | Core reset, active low; clears the response registers only |
| bus_req | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_lock | input | 1 | Locked-transaction flag |
| bus_addr | input | ADDR_W-2 | Dword address (byte address bits ADDR_W-1:2) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for write data |
| cfg_mem_en | input | 1 | Memory-space decode enable |
| cfg_pwr_d3 | input | 1 | Function is in the D3 power state |
| cfg_wr_unlock | input | 1 | Allows writes to the structural-parameters word |
| bus_claim | output | 1 | The block took the previous cycle's request |
| bus_abort | output | 1 | The claimed request was rejected with a master abort |
| bus_rdata | output | 32 | Read data for the previous cycle's request |

## Verification
The bench goes after the priority order. It sends locked and D3 accesses with decode disabled, so a design that checks the abort causes before the enable would claim a cycle that belongs to another target. It sends locked and D3 writes with unlock high, which catches a design that commits the write before it evaluates the abort. Partial byte-enable patterns catch full-word or misordered lane updates. A core-reset pulse between writing and reading the structural-parameters word catches a design that ties that word to the wrong reset. Writes to the fixed words and reads from 0Ch–1Ch catch index decoding that aliases onto the writable word.

// File: rtl/hccap_pkg.sv
package hccap_pkg;

   // qualified request, one cycle wide
   typedef struct packed {
      logic hit;    // claimed: enabled and inside the window
      logic abort;  // claimed but rejected (lock or D3)
      logic rd;     // accepted read
      logic wr;     // accepted write
   } hccap_qual_t;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_BITS  = 8 * WORD_BYTES;

   // word indices inside the window; the software view depends on them
   localparam int unsigned IDX_CAPVER  = 0;
   localparam int unsigned IDX_SPARAMS = 1;
   localparam int unsigned IDX_CPARAMS = 2;

endpackage

// File: rtl/hccap_gate.sv
module hccap_gate
   import hccap_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 32,
   parameter int unsigned       WIN_BITS = 5,
   parameter logic [ADDR_W-1:0] BASE     = '0,
   localparam int unsigned      IW       = WIN_BITS - 2
)(
   input  logic                req,
   input  logic                we,
   input  logic                lock,
   input  logic [ADDR_W-1:2]   addr,
   input  logic                mem_en,
   input  logic                pwr_d3,
   output hccap_qual_t         qual,
   output logic [IW-1:0]       widx
);

   logic in_win;

   // window match on the bits above the window size
   assign in_win = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);

   // decode enable gates everything; lock and D3 override a normal access
   always_comb begin
      qual.hit   = req & mem_en & in_win;
      qual.abort = qual.hit & (lock | pwr_d3);
      qual.rd    = qual.hit & ~qual.abort & ~we;
      qual.wr    = qual.hit & ~qual.abort &  we;
   end

   assign widx = addr[WIN_BITS-1:2];

endmodule

// File: rtl/hccap_sparams.sv
module hccap_sparams
   import hccap_pkg::*;
#(
   parameter logic [WORD_BITS-1:0] RST_VAL = 32'h0010_4208
)(
   input  logic                  clk,
   input  logic                  rst_n,     // suspend-well reset only
   input  logic                  wr_sel,
   input  logic                  unlock,
   input  logic [WORD_BYTES-1:0] be,
   input  logic [WORD_BITS-1:0]  wdata,
   output logic [WORD_BITS-1:0]  q
);

   logic wr_ok;
   assign wr_ok = wr_sel & unlock;

   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[8*b +: 8] <= RST_VAL[8*b +: 8];
         else if (wr_ok && be[b])
            q[8*b +: 8] <= wdata[8*b +: 8];
      end
   end

   AST_SP_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !unlock |=> $stable(q)); // R9

   AST_SP_ONLY_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel |=> $stable(q)); // R6

   AST_SP_MASKED_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && unlock && be == '0) |=> $stable(q)); // R8

endmodule

// File: rtl/hccap_rdmux.sv
module hccap_rdmux
   import hccap_pkg::*;
#(
   parameter int unsigned          WIN_BITS = 5,
   parameter logic [7:0]           CAPLEN   = 8'h20,
   parameter logic [15:0]          VERSION  = 16'h0100,
   parameter logic [WORD_BITS-1:0] CPARAMS  = 32'h0000_6871,
   localparam int unsigned         IW       = WIN_BITS - 2,
   localparam int unsigned         NWORDS   = 1 << IW
)(
   input  logic [IW-1:0]          widx,
   input  logic [WORD_BITS-1:0]   sparams,
   output logic [WORD_BITS-1:0]   rdata
);

   logic [WORD_BITS-1:0] words [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      if (w == IDX_CAPVER) begin : g_capver
         assign words[w] = {VERSION, 8'h00, CAPLEN};
      end else if (w == IDX_SPARAMS) begin : g_sp
         assign words[w] = sparams;
      end else if (w == IDX_CPARAMS) begin : g_cp
         assign words[w] = CPARAMS;
      end else begin : g_zero
         assign words[w] = '0;
      end
   end

   assign rdata = words[widx];

endmodule

// File: rtl/hccap_decoder.sv
module hccap_decoder
   import hccap_pkg::*;
#(
   parameter int unsigned          ADDR_W      = 32,
   parameter int unsigned          WIN_BITS    = 5,
   parameter logic [ADDR_W-1:0]    BASE        = 32'hFEB0_0000,
   parameter logic [7:0]           CAPLEN      = 8'h20,
   parameter logic [15:0]          VERSION     = 16'h0100,
   parameter logic [WORD_BITS-1:0] SPARAMS_RST = 32'h0010_4208,
   parameter logic [WORD_BITS-1:0] CPARAMS     = 32'h0000_6871
)(
   input  logic                  clk,
   input  logic                  rst_sw_n,
   input  logic                  rst_core_n,
   input  logic                  bus_req,
   input  logic                  bus_we,
   input  logic                  bus_lock,
   input  logic [ADDR_W-1:2]     bus_addr,
   input  logic [WORD_BITS-1:0]  bus_wdata,
   input  logic [WORD_BYTES-1:0] bus_be,
   input  logic                  cfg_mem_en,
   input  logic                  cfg_pwr_d3,
   input  logic                  cfg_wr_unlock,
   output logic                  bus_claim,
   output logic                  bus_abort,
   output logic [WORD_BITS-1:0]  bus_rdata
);

   localparam int unsigned   IW     = WIN_BITS - 2;
   localparam logic [IW-1:0] SP_IDX = IW'(IDX_SPARAMS);

   // elaboration-time parameter checks
   if (WIN_BITS < 4 || WIN_BITS >= ADDR_W) begin : g_bad_win
      $error("hccap_decoder: WIN_BITS must hold three words and fit ADDR_W");
   end
   if (BASE[WIN_BITS-1:0] != '0) begin : g_bad_base
      $error("hccap_decoder: BASE must be aligned to the window size");
   end
   if (32'(CAPLEN) != (32'd1 << WIN_BITS)) begin : g_bad_len
      $error("hccap_decoder: CAPLEN must equal the window size");
   end

   hccap_qual_t          qual;
   logic [IW-1:0]        widx;
   logic [WORD_BITS-1:0] sp_q;
   logic [WORD_BITS-1:0] mux_data;

   hccap_gate #(
      .ADDR_W   (ADDR_W),
      .WIN_BITS (WIN_BITS),
      .BASE     (BASE)
   ) u_gate (
      .req    (bus_req),
      .we     (bus_we),
      .lock   (bus_lock),
      .addr   (bus_addr),
      .mem_en (cfg_mem_en),
      .pwr_d3 (cfg_pwr_d3),
      .qual   (qual),
      .widx   (widx)
   );

   hccap_sparams #(
      .RST_VAL (SPARAMS_RST)
   ) u_sparams (
      .clk    (clk),
      .rst_n  (rst_sw_n),
      .wr_sel (qual.wr && (widx == SP_IDX)),
      .unlock (cfg_wr_unlock),
      .be     (bus_be),
      .wdata  (bus_wdata),
      .q      (sp_q)
   );

   hccap_rdmux #(
      .WIN_BITS (WIN_BITS),
      .CAPLEN   (CAPLEN),
      .VERSION  (VERSION),
      .CPARAMS  (CPARAMS)
   ) u_rdmux (
      .widx    (widx),
      .sparams (sp_q),
      .rdata   (mux_data)
   );

   // response stage in the core reset domain
   always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) begin
         bus_claim <= 1'b0;
         bus_abort <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_claim <= qual.hit;
         bus_abort <= qual.abort;
         bus_rdata <= qual.rd ? mux_data : '0;
      end
   end

   AST_NO_CLAIM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_core_n)
      (bus_req && !cfg_mem_en) |=> (!bus_claim && !bus_abort)); // R1

   AST_ABORT_IMPLIES_CLAIM: assert property (@(posedge clk) disable iff (!rst_core_n)
      bus_abort |-> bus_claim); // R3

   AST_LOCK_ABORTS: assert property (@(posedge clk) disable iff (!rst_core_n)
      (qual.hit && bus_lock) |=> (bus_abort && bus_rdata == '0)); // R3

   AST_D3_ABORTS: assert property (@(posedge clk) disable iff (!rst_core_n)
      (qual.hit && cfg_pwr_d3) |=> (bus_abort && bus_rdata == '0)); // R4

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
      !bus_req |=> (!bus_claim && !bus_abort && bus_rdata == '0)); // R12

   AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_sw_n)
      qual.abort |=> $stable(sp_q)); // R4

endmodule

// File: tb/hccap_decoder_bench.sv
module hccap_decoder_bench;

   localparam logic [31:0] BASE = 32'hFEB0_0000;

   logic        clk = 1'b0;
   logic        rst_sw_n, rst_core_n;
   logic        bus_req, bus_we, bus_lock;
   logic [31:2] bus_addr;
   logic [31:0] bus_wdata;
   logic [3:0]  bus_be;
   logic        cfg_mem_en, cfg_pwr_d3, cfg_wr_unlock;
   logic        bus_claim, bus_abort;
   logic [31:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   logic [31:0] m_sp;
   logic        e_claim, e_abort;
   logic [31:0] e_rdata;

   always #4 clk = ~clk;   // 125 MHz

   hccap_decoder #(.BASE(BASE)) u_hccap_decoder (
      .clk(clk), .rst_sw_n(rst_sw_n), .rst_core_n(rst_core_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_lock(bus_lock),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
      .cfg_mem_en(cfg_mem_en), .cfg_pwr_d3(cfg_pwr_d3),
      .cfg_wr_unlock(cfg_wr_unlock),
      .bus_claim(bus_claim), .bus_abort(bus_abort), .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] ref_word(input logic [31:0] off);
      case (off[4:2])
         3'd0:    return 32'h0100_0020;
         3'd1:    return m_sp;
         3'd2:    return 32'h0000_6871;
         default: return 32'h0;
      endcase
   endfunction

   task automatic compare(input string tag);
      checks++;
      if (bus_claim !== e_claim || bus_abort !== e_abort || bus_rdata !== e_rdata) begin
         fails++;
         $display("FAIL %s: claim/abort/rdata actual %b/%b/%h expected %b/%b/%h",
                  tag, bus_claim, bus_abort, bus_rdata, e_claim, e_abort, e_rdata);
      end
   endtask

   // one access: drive after a falling edge, compare at the next falling edge
   task automatic access(input logic we, input logic lock, input logic [31:0] byte_addr,
                         input logic [31:0] wd, input logic [3:0] be, input string tag);
      logic hit, ab;
      bus_req = 1'b1; bus_we = we; bus_lock = lock;
      bus_addr = byte_addr[31:2]; bus_wdata = wd; bus_be = be;
      hit = cfg_mem_en && (byte_addr[31:5] == BASE[31:5]);
      ab  = hit && (lock || cfg_pwr_d3);
      e_claim = hit;
      e_abort = ab;
      e_rdata = (hit && !ab && !we) ? ref_word(byte_addr) : 32'h0;
      @(posedge clk);
      if (hit && !ab && we && cfg_wr_unlock && byte_addr[4:2] == 3'd1)
         for (int b = 0; b < 4; b++)
            if (be[b]) m_sp[8*b +: 8] = wd[8*b +: 8];
      @(negedge clk);
      bus_req = 1'b0;
      compare(tag);
   endtask

   task automatic idle(input string tag);
      bus_req = 1'b0;
      e_claim = 1'b0; e_abort = 1'b0; e_rdata = 32'h0;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      rst_sw_n = 1'b0; rst_core_n = 1'b0;
      bus_req = 1'b0; bus_we = 1'b0; bus_lock = 1'b0;
      bus_addr = '0; bus_wdata = '0; bus_be = '0;
      cfg_mem_en = 1'b1; cfg_pwr_d3 = 1'b0; cfg_wr_unlock = 1'b0;
      m_sp = 32'h0010_4208;
      repeat (3) @(negedge clk);
      rst_sw_n = 1'b1; rst_core_n = 1'b1;

      idle("R12 reset state");
      access(0, 0, BASE + 32'h00, '0, 4'h0, "R5 capver read");
      access(0, 0, BASE + 32'h08, '0, 4'h0, "R6 cparams read");
      cfg_wr_unlock = 1'b1;
      access(1, 0, BASE + 32'h08, 32'hFFFF_FFFF, 4'hF, "R6 cparams write claimed");
      access(1, 0, BASE + 32'h00, 32'hFFFF_FFFF, 4'hF, "R6 capver write claimed");
      access(0, 0, BASE + 32'h08, '0, 4'h0, "R6 cparams unchanged");
      access(0, 0, BASE + 32'h00, '0, 4'h0, "R6 capver unchanged");
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R7 sparams reset value");
      cfg_wr_unlock = 1'b0;
      access(1, 0, BASE + 32'h04, 32'h1234_5678, 4'hF, "R9 locked-reg write");
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R9 sparams unchanged");
      cfg_wr_unlock = 1'b1;
      access(1, 0, BASE + 32'h04, 32'hAABB_CCDD, 4'b0101, "R8 partial write");
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R8 lanes 0 and 2");
      access(1, 0, BASE + 32'h04, 32'h1122_3344, 4'b1000, "R8 top lane write");
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R8 lane 3");
      access(1, 0, BASE + 32'h04, 32'h5566_7788, 4'b0000, "R8 no lanes");
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R8 no lanes readback");
      for (int o = 12; o < 32; o += 4)
         access(0, 0, BASE + 32'(o), '0, 4'h0, "R11 unused offset");
      access(1, 1, BASE + 32'h04, 32'h0, 4'hF, "R3 locked write");
      access(0, 1, BASE + 32'h04, '0, 4'h0, "R3 locked read");
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R3 sparams kept");
      cfg_pwr_d3 = 1'b1;
      access(1, 0, BASE + 32'h04, 32'h0, 4'hF, "R4 D3 write");
      access(0, 0, BASE + 32'h00, '0, 4'h0, "R4 D3 read");
      cfg_pwr_d3 = 1'b0;
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R4 sparams kept");
      cfg_mem_en = 1'b0;
      access(0, 0, BASE + 32'h00, '0, 4'h0, "R1 disabled read");
      access(1, 0, BASE + 32'h04, 32'h0, 4'hF, "R1 disabled write");
      access(0, 1, BASE + 32'h04, '0, 4'h0, "R1 disabled over lock");
      cfg_pwr_d3 = 1'b1;
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R1 disabled over D3");
      cfg_pwr_d3 = 1'b0;
      cfg_mem_en = 1'b1;
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R1 sparams kept");
      access(0, 0, BASE + 32'h20, '0, 4'h0, "R2 above window");
      access(0, 0, BASE - 32'h4, '0, 4'h0, "R2 below window");
      access(1, 0, BASE + 32'h24, 32'h0, 4'hF, "R2 write above window");
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R2 sparams kept");
      access(1, 0, BASE + 32'h04, 32'hCAFE_F00D, 4'hF, "R12 write returns zero");
      rst_core_n = 1'b0;
      e_claim = 1'b0; e_abort = 1'b0; e_rdata = 32'h0;
      @(negedge clk);
      compare("R10 outputs cleared in core reset");
      @(negedge clk);
      rst_core_n = 1'b1;
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R10 sparams survives core reset");
      rst_sw_n = 1'b0;
      m_sp = 32'h0010_4208;
      @(negedge clk);
      rst_sw_n = 1'b1;
      access(0, 0, BASE + 32'h04, '0, 4'h0, "R7 suspend reset restores");
      idle("R12 idle after traffic");

      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule